// File: doc/BRIEF.md
# BPSK Subcarrier Answer Transmitter

This block builds the answer a contactless tag sends back to a reader. It produces a single load-modulation control bit. A start pulse and a byte count launch a transmission. The block then stays silent for a turnaround interval and sends a plain subcarrier so the reader can lock its phase. After that it sends the start-of-frame pattern, one 10-bit character per payload byte, two CRC characters that it computes itself, and the end-of-frame pattern.

The subcarrier is the carrier clock divided by 16, which gives 847.5 kHz from a 13.56 MHz carrier. Every logic level after the synchronisation interval is carried as subcarrier phase, not as an amplitude. A level of 1 keeps the phase used during synchronisation. A level of 0 inverts it. As a result, the step from synchronisation into the first start-of-frame zero is the first phase reversal the reader sees.

The command logic supplies the payload as a flat byte vector. That vector is read while the frame is being sent, so the command logic must hold it steady until the frame ends.

Top module: `bpskAnswerTx`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, `modOut`, `busy` and `done` are all 0.
- R2: A start sampled while idle raises `busy` in the next cycle. For the following 2048 clocks (128 subcarrier periods of 16 clocks), `modOut` stays 0.
- R3: For the next 2048 clocks, `modOut` is an unmodulated square wave with a period of 16 clocks. It is high for the first 8 clocks of each period, counted from the first synchronisation clock. This defines the reference phase.
- R4: Each frame bit lasts 128 clocks, which is 8 subcarrier periods. A bit of 1 is sent with the reference phase and a bit of 0 with the inverted phase. The frame opens with 10 bits of 0 followed by 2 bits of 1.
- R5: Payload byte i is taken from `txData[8i+7:8i]`, starting with i = 0. Each byte is sent as a 0 start bit, then its 8 bits least significant first, then a 1 stop bit.
- R6: After the payload come two characters of the same format holding a CRC, low byte first. The CRC is the reflected polynomial 0x8408, preset to FFFFh, run over every payload bit in send order, then complemented. For the ASCII bytes "123456789" the result is 0x906E.
- R7: The frame closes with 10 bits of 0 followed by 2 bits of 1. After that, `modOut` is 0.
- R8: `busy` stays high for exactly 4096 + 128·(24 + 10·(N+2)) clocks for N payload bytes. `done` pulses for one cycle in the first cycle after `busy` falls.
- R9: A start sampled while `busy` is high is ignored. This includes a start on the final cycle of the frame. A start sampled in the `done` cycle is accepted.
- R10: A byte count of 0 sends only the two CRC characters, which are 0x00 0x00. A byte count above `MAX_BYTES` is treated as `MAX_BYTES`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock (13.56 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; accepted only when idle |
| byteCount | input | 5 | Number of payload bytes, latched at start |
| txData | input | 128 | Payload bytes; byte i at bits 8i+7..8i; must stay stable while busy |
| modOut | output | 1 | Load-modulation control (BPSK subcarrier) |
| busy | output | 1 | High from the turnaround start until the last end-of-frame bit |
| done | output | 1 | One-cycle pulse after the frame ends |

## Verification
Two events can land on the same clock edge: the end of one frame and the request for the next one. To provoke this, the bench raises `start` on the last cycle of an end-of-frame pattern and keeps it high through the following `done` cycle. The first sample must be discarded and the second must launch a new turnaround at once. A cycle-accurate model built from the requirements judges every clock of both frames. It checks that nothing is lost, that nothing is duplicated and that the phase reference is restarted correctly. A separate check confirms that `done` and a low `busy` appear together in that cycle, with `busy` rising again one cycle later.

// File: rtl/bpskTxPkg.sv
package bpskTxPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_SYNC,
    ST_SOF,
    ST_CHAR,
    ST_EOF
  } txStateE;

  // Strobes issued by the sequencer to the datapath, one clock each.
  typedef struct packed {
    logic frameInit;  // preset CRC, realign subcarrier
    logic loadMark;   // load 10x0 + 2x1 frame mark
    logic loadData;   // load payload character
    logic loadCrcLo;  // load CRC low character
    logic loadCrcHi;  // load CRC high character
    logic shift;      // advance to next bit
    logic crcStep;    // fold current bit into CRC
    logic modEn;      // subcarrier on the output
    logic syncMode;   // reference phase, no data
  } txStrobeS;

  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

endpackage

// File: rtl/bpskTxCtrl.sv
module bpskTxCtrl
  import bpskTxPkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int SUB_DIV   = 16,
  parameter int T0_SUB    = 128,
  parameter int T1_SUB    = 128,
  parameter int ETU_SUB   = 8,
  localparam int BC_W     = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [BC_W-1:0]  byteCount,
  output txStrobeS         stb,
  output logic [IDX_W-1:0] byteSel,
  output logic             busy,
  output logic             done
);

  localparam int T0_CLK  = T0_SUB * SUB_DIV;
  localparam int T1_CLK  = T1_SUB * SUB_DIV;
  localparam int ETU_CLK = ETU_SUB * SUB_DIV;
  localparam int LONGEST = (T0_CLK > T1_CLK) ? ((T0_CLK > ETU_CLK) ? T0_CLK : ETU_CLK)
                                             : ((T1_CLK > ETU_CLK) ? T1_CLK : ETU_CLK);
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int CI_W    = $clog2(MAX_BYTES + 3);
  localparam int MARK_LAST = 11;
  localparam int CHAR_LAST = 9;

  txStateE stQ, stD;
  logic [TW-1:0]   tmrQ;
  logic [3:0]      bitQ;
  logic [CI_W-1:0] chrQ, chrNext, lenQ;
  logic            doneQ, tick, loadChar;
  int              lim;

  always_comb begin
    unique case (stQ)
      ST_GAP:  lim = T0_CLK;
      ST_SYNC: lim = T1_CLK;
      default: lim = ETU_CLK;
    endcase
  end

  assign tick    = (int'(tmrQ) == lim - 1);
  assign chrNext = (stQ == ST_SOF) ? '0 : chrQ + CI_W'(1);
  assign byteSel = chrNext[IDX_W-1:0];

  always_comb begin
    stb          = '0;
    stD          = stQ;
    loadChar     = 1'b0;
    stb.modEn    = (stQ != ST_IDLE) && (stQ != ST_GAP);
    stb.syncMode = (stQ == ST_SYNC);
    unique case (stQ)
      ST_IDLE: if (start) begin
        stb.frameInit = 1'b1;
        stD           = ST_GAP;
      end
      ST_GAP: if (tick) stD = ST_SYNC;
      ST_SYNC: if (tick) begin
        stb.loadMark = 1'b1;
        stD          = ST_SOF;
      end
      ST_SOF: if (tick) begin
        if (int'(bitQ) == MARK_LAST) begin
          loadChar = 1'b1;
          stD      = ST_CHAR;
        end else stb.shift = 1'b1;
      end
      ST_CHAR: if (tick) begin
        if (int'(bitQ) == CHAR_LAST) begin
          if (chrQ == lenQ + CI_W'(1)) begin
            stb.loadMark = 1'b1;
            stD          = ST_EOF;
          end else loadChar = 1'b1;
        end else begin
          stb.shift   = 1'b1;
          stb.crcStep = (chrQ < lenQ) && (bitQ >= 4'd1) && (bitQ <= 4'd8);
        end
      end
      ST_EOF: if (tick) begin
        if (int'(bitQ) == MARK_LAST) stD = ST_IDLE;
        else stb.shift = 1'b1;
      end
      default: stD = ST_IDLE;
    endcase
    if (loadChar) begin
      if (chrNext < lenQ)       stb.loadData  = 1'b1;
      else if (chrNext == lenQ) stb.loadCrcLo = 1'b1;
      else                      stb.loadCrcHi = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      tmrQ  <= '0;
      bitQ  <= '0;
      chrQ  <= '0;
      lenQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      stQ   <= stD;
      doneQ <= (stQ == ST_EOF) && (stD == ST_IDLE);
      if (stQ == ST_IDLE || tick) tmrQ <= '0;
      else                        tmrQ <= tmrQ + TW'(1);
      if (stb.shift)                  bitQ <= bitQ + 4'd1;
      else if (tick || stD != stQ)    bitQ <= '0;
      if (stb.frameInit) begin
        chrQ <= '0;
        lenQ <= (int'(byteCount) > MAX_BYTES) ? CI_W'(MAX_BYTES) : CI_W'(byteCount);
      end else if (loadChar) chrQ <= chrNext;
    end
  end

  assign busy = (stQ != ST_IDLE);
  assign done = doneQ;

  // R8: the completion pulse only follows the closing mark
  p_done_after_eof_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(stQ) == ST_EOF);

  // R9: a start arriving mid-frame never restarts the turnaround
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != ST_IDLE && stQ != ST_GAP && start) |=> stQ != ST_GAP);

  // R5: characters are only entered from the opening mark
  p_char_after_sof_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_CHAR && $past(stQ) != ST_CHAR) |-> $past(stQ) == ST_SOF);

  // R6: the closing mark follows exactly the second CRC character
  p_eof_after_crc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_EOF && $past(stQ) == ST_CHAR) |-> $past(chrQ) == lenQ + CI_W'(1));

endmodule

// File: rtl/bpskTxDatapath.sv
module bpskTxDatapath
  import bpskTxPkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int SUB_DIV   = 16,
  localparam int IDX_W    = $clog2(MAX_BYTES),
  localparam int SC_W     = $clog2(SUB_DIV)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  txStrobeS               stb,
  input  logic [IDX_W-1:0]       byteSel,
  input  logic [MAX_BYTES*8-1:0] txData,
  output logic                   modOut
);

  localparam int HALF = SUB_DIV / 2;

  logic [SC_W-1:0] subCnt;
  logic [11:0]     charSr;
  logic [15:0]     crcQ;
  logic [7:0]      curByte;
  logic            subClk, level, fb;

  assign curByte = txData[int'(byteSel)*8 +: 8];
  assign subClk  = (int'(subCnt) < HALF);
  assign level   = stb.syncMode ? 1'b1 : charSr[0];
  assign fb      = crcQ[0] ^ charSr[0];
  assign modOut  = stb.modEn & (subClk ^ ~level);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt <= '0;
      charSr <= '0;
      crcQ   <= CRC_PRESET;
    end else begin
      if (stb.frameInit || int'(subCnt) == SUB_DIV - 1) subCnt <= '0;
      else                                             subCnt <= subCnt + SC_W'(1);

      if (stb.frameInit)    crcQ <= CRC_PRESET;
      else if (stb.crcStep) crcQ <= {1'b0, crcQ[15:1]} ^ (fb ? CRC_POLY : 16'h0000);

      if (stb.loadMark)       charSr <= 12'b1100_0000_0000;
      else if (stb.loadData)  charSr <= {3'b001, curByte, 1'b0};
      else if (stb.loadCrcLo) charSr <= {3'b001, ~crcQ[7:0], 1'b0};
      else if (stb.loadCrcHi) charSr <= {3'b001, ~crcQ[15:8], 1'b0};
      else if (stb.shift)     charSr <= {1'b0, charSr[11:1]};
    end
  end

  // R6: the CRC is frozen while its low character is on the air
  p_crc_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCrcHi |-> $stable(crcQ));

  // R4: inside one bit the output moves only on subcarrier half edges
  p_phase_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.modEn && $past(stb.modEn) && $stable(charSr) && $stable(stb.syncMode)
     && int'($past(subCnt)) != HALF - 1 && int'($past(subCnt)) != SUB_DIV - 1)
    |-> $stable(modOut));

endmodule

// File: rtl/bpskAnswerTx.sv
module bpskAnswerTx
  import bpskTxPkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int SUB_DIV   = 16,
  parameter int T0_SUB    = 128,
  parameter int T1_SUB    = 128,
  parameter int ETU_SUB   = 8,
  localparam int BC_W     = $clog2(MAX_BYTES + 1),
  localparam int IDX_W    = $clog2(MAX_BYTES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [BC_W-1:0]        byteCount,
  input  logic [MAX_BYTES*8-1:0] txData,
  output logic                   modOut,
  output logic                   busy,
  output logic                   done
);

  txStrobeS         stb;
  logic [IDX_W-1:0] byteSel;

  bpskTxCtrl #(
    .MAX_BYTES(MAX_BYTES), .SUB_DIV(SUB_DIV), .T0_SUB(T0_SUB),
    .T1_SUB(T1_SUB), .ETU_SUB(ETU_SUB)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .stb(stb), .byteSel(byteSel), .busy(busy), .done(done)
  );

  bpskTxDatapath #(
    .MAX_BYTES(MAX_BYTES), .SUB_DIV(SUB_DIV)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .byteSel(byteSel),
    .txData(txData), .modOut(modOut)
  );

  // R1: nothing is emitted while idle
  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !modOut);

endmodule

// File: tb/bpskAnswerTx_bench.sv
module bpskAnswerTx_bench;

  localparam int MAXB   = 16;
  localparam int ETU    = 128;
  localparam int PREAMB = 4096;

  logic             clk = 1'b0;
  logic             rstN, start;
  logic [4:0]       byteCount;
  logic [MAXB*8-1:0] txData;
  logic             modOut, busy, done;

  always #4 clk = ~clk;

  bpskAnswerTx u_bpskAnswerTx (
    .clk(clk), .rstN(rstN), .start(start), .byteCount(byteCount),
    .txData(txData), .modOut(modOut), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit   mBits[$];
  bit   mActive = 0, mDone = 0, wasActive;
  int   mN = 0, mTotal = 0, mLen = 0;
  bit   forceCrcEn = 0;
  logic [15:0] forceCrc = 16'h0;

  task automatic pushChar(input logic [7:0] b);
    mBits.push_back(1'b0);
    for (int k = 0; k < 8; k++) mBits.push_back(b[k]);
    mBits.push_back(1'b1);
  endtask

  task automatic buildFrame(input int bc, input logic [MAXB*8-1:0] d);
    logic [15:0] c;
    c    = 16'hFFFF;
    mLen = (bc > MAXB) ? MAXB : bc;
    mBits.delete();
    repeat (10) mBits.push_back(1'b0);
    repeat (2)  mBits.push_back(1'b1);
    for (int i = 0; i < mLen; i++) begin
      logic [7:0] by;
      by = d[8*i +: 8];
      pushChar(by);
      for (int k = 0; k < 8; k++) begin
        logic f;
        f = c[0] ^ by[k];
        c = {1'b0, c[15:1]};
        if (f) c = c ^ 16'h8408;
      end
    end
    c = ~c;
    if (forceCrcEn) c = forceCrc;
    pushChar(c[7:0]);
    pushChar(c[15:8]);
    repeat (10) mBits.push_back(1'b0);
    repeat (2)  mBits.push_back(1'b1);
    mTotal = PREAMB + mBits.size() * ETU;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mActive = 0; mDone = 0; mN = 0;
    end else begin
      wasActive = mActive;
      mDone = 0;
      if (mActive) begin
        mN++;
        if (mN == mTotal) begin mActive = 0; mDone = 1; end
      end
      if (!wasActive && start) begin
        buildFrame(int'(byteCount), txData);
        mActive = 1; mN = 0;
      end
    end
  end

  function automatic string regionTag(input int n);
    int b;
    if (n < 2048) return "R2";
    if (n < PREAMB) return "R3";
    b = (n - PREAMB) / ETU;
    if (b < 12) return "R4";
    if (b < 12 + 10 * mLen) return "R5";
    if (b < 32 + 10 * mLen) return "R6";
    return "R7";
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      bit expMod, sc;
      string tag;
      sc = ((mN % 16) < 8);
      if (!mActive) begin expMod = 0; tag = "R7"; end
      else if (mN < 2048) begin expMod = 0; tag = regionTag(mN); end
      else if (mN < PREAMB) begin expMod = sc; tag = regionTag(mN); end
      else begin
        expMod = sc ^ !mBits[(mN - PREAMB) / ETU];
        tag = regionTag(mN);
      end
      chk(modOut == expMod, tag, int'(modOut), int'(expMod));
      chk(busy == mActive, "R8 busy", int'(busy), int'(mActive));
      chk(done == mDone, "R8 done", int'(done), int'(mDone));
    end
  end

  // ---------------- stimulus ----------------
  task automatic runFrame(input int bc, input int midStartAt, input string tag);
    int n, exp, len;
    len = (bc > MAXB) ? MAXB : bc;
    exp = PREAMB + ETU * (24 + 10 * (len + 2));
    @(negedge clk); byteCount = 5'(bc); start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (busy) begin
      start = (n == midStartAt);
      if (n == midStartAt) byteCount = 5'd3;
      n++;
      @(negedge clk);
    end
    start = 0;
    chk(n == exp, tag, n, exp);
    chk(done == 1'b1, tag, int'(done), 1);
  endtask

  task automatic finishRun;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    rstN = 0; start = 0; byteCount = '0; txData = '0;
    repeat (3) @(negedge clk);
    chk(modOut == 0, "R1", int'(modOut), 0);
    chk(busy == 0,   "R1", int'(busy), 0);
    chk(done == 0,   "R1", int'(done), 0);
    @(negedge clk); rstN = 1;
    repeat (20) @(negedge clk);
    chk(busy == 0 && modOut == 0, "R1 idle", int'(busy), 0);

    // one byte, alternating pattern
    txData = '0; txData[7:0] = 8'hA5;
    runFrame(1, -1, "R8 one byte");

    // three bytes, mixed pattern
    txData[23:0] = 24'h0F_FF_00;
    runFrame(3, -1, "R5 three bytes");

    // known CRC vector "123456789"
    for (int i = 0; i < 9; i++) txData[8*i +: 8] = 8'h31 + 8'(i);
    forceCrcEn = 1; forceCrc = 16'h906E;
    runFrame(9, -1, "R6 known vector");
    forceCrcEn = 0;

    // empty payload
    runFrame(0, -1, "R10 empty");

    // clamped byte count
    for (int i = 0; i < MAXB; i++) txData[8*i +: 8] = 8'(8'h11 * i + 3);
    runFrame(31, -1, "R10 clamp");

    // start in the middle of a frame is ignored
    txData[15:0] = 16'h3C81;
    runFrame(2, 6000, "R9 mid-frame");

    // start on the final cycle and in the done cycle
    txData[7:0] = 8'h5A;
    @(negedge clk); byteCount = 5'd1; start = 1;
    @(negedge clk); start = 0;
    while (!(mActive && mN == mTotal - 1)) @(negedge clk);
    start = 1; byteCount = 5'd2;
    @(negedge clk);
    chk(busy == 0 && done == 1, "R9 done cycle", int'(busy), 0);
    @(negedge clk); start = 0;
    chk(busy == 1, "R9 restart", int'(busy), 1);
    while (busy) @(negedge clk);
    chk(done == 1, "R8 second frame", int'(done), 1);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule